// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a byte-addressed serial EEPROM on a two-wire bus. A fast system clock samples the bus clock and data lines through synchronisers. The block finds start and stop conditions and checks the device byte against a fixed four-bit code. It then takes a two-byte word address and either accepts one data byte for writing or shifts out data bytes from its internal address counter. The data line is open-drain: the block only ever pulls it low or lets it go.

A write reaches the memory port only when the master closes the transaction with a stop. That stop also starts an internal write cycle, modelled by a cycle-count timer. While the timer runs, the block refuses its device byte, so a host can poll with start plus device byte until the acknowledge returns. The address counter advances differently after each kind of access. After a write it wraps inside the current page, and after a read it wraps across the whole array. A transfer that sends only the word address moves the counter without writing anything, so a following read starts at any chosen location.

Top module: `eep_2w_slave`

## Requirements
- R1: A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. Either condition aborts any byte in progress. A start returns the engine to device-byte receive, and a stop returns it to idle.
- R2: The device byte is acknowledged (SDA pulled low for the ninth clock) only when its upper four bits are 1010 and no write cycle is busy. Bits 3..1 are ignored, and bit 0 set to 1 selects a read. After a refused device byte the engine releases SDA and ignores the bus until the next start.
- R3: For BUSY_CYCLES clocks after a write is committed, device bytes are not acknowledged. After that time a device byte is acknowledged again.
- R4: In a write transfer the two bytes after the device byte form the word address, high byte first. Both bytes are acknowledged, and high-byte bits above ADDR_W are ignored.
- R5: Exactly one data byte per write transfer is acknowledged and held. A further data byte in the same transfer is not acknowledged and does not replace the held byte.
- R6: The held byte is written only on a stop: one clock of mem_we_o with mem_addr_o equal to the word address and mem_wdata_o equal to the byte. A start arriving before the stop discards the held byte, and no write takes place.
- R7: After a write the counter is the written address with its low PAGE_W bits incremented modulo the page size. The upper bits stay unchanged, so the last byte of a page is followed by the first byte of the same page.
- R8: In a read, each byte is the memory content at the counter and is sent MSB first. SDA changes only while SCL is low.
- R9: After each byte sent, the counter increments modulo 2^ADDR_W, so the last array address is followed by address 0.
- R10: A master acknowledge on the ninth clock of a read byte continues with the next byte. A master non-acknowledge releases SDA, and later clocks read as all ones until a new start.
- R11: A write transfer stopped after the word address only sets the counter. It produces no memory write and no busy time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_we_o | output | 1 | One-clock write strobe to the array |
| mem_addr_o | output | ADDR_W | Array address, equal to the internal counter |
| mem_wdata_o | output | 8 | Byte to write |
| mem_rdata_i | input | 8 | Array content at mem_addr_o, valid one clock after the address |

## Verification
The bench polls right after a committed write. A design that ignored the busy timer would acknowledge the first poll, and one that never cleared it would never acknowledge. Writes at the last byte of a page and reads across the top of the array separate the two wrap rules; a design that shared one increment would read from the wrong page or past the end. A repeated start after a data byte, a second data byte, and a stop in the middle of a device byte check that nothing is committed early. A second data byte must neither be acknowledged nor overwrite the first. A non-acknowledged read must leave SDA released rather than keep shifting data.

// File: rtl/eep_2w_pkg.sv
package eep_2w_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_DATA,
      ST_RD
   } eep_state_e;

endpackage

// File: rtl/eep_2w_line_sync.sv
module eep_2w_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);

   logic [STAGES-1:0] scl_ch, sda_ch;
   logic              scl_d, sda_d;

   // Bus idles high, so the chains reset to ones.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ch <= '1;
         sda_ch <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_ch <= {scl_ch[STAGES-2:0], scl_i};
         sda_ch <= {sda_ch[STAGES-2:0], sda_i};
         scl_d  <= scl_ch[STAGES-1];
         sda_d  <= sda_ch[STAGES-1];
      end
   end

   assign scl_o   = scl_ch[STAGES-1];
   assign sda_o   = sda_ch[STAGES-1];
   assign start_o = scl_o & scl_d & sda_d & ~sda_o;
   assign stop_o  = scl_o & scl_d & ~sda_d & sda_o;
   assign rise_o  = scl_o & ~scl_d;
   assign fall_o  = ~scl_o & scl_d;

endmodule

// File: rtl/eep_2w_busy_timer.sv
module eep_2w_busy_timer #(
   parameter int CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_i,
   output logic busy_o
);

   localparam int CW = $clog2(CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (kick_i)         cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/eep_2w_slave.sv
module eep_2w_slave #(
   parameter int          ADDR_W      = 14,
   parameter int          PAGE_W      = 6,
   parameter int          BUSY_CYCLES = 250000,
   parameter int          SYNC_STAGES = 2,
   parameter logic [3:0]  DEV_CODE    = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [7:0]        mem_wdata_o,
   input  logic [7:0]        mem_rdata_i
);
   import eep_2w_pkg::*;

   localparam int AHI_W = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
         $error("eep_2w_slave: ADDR_W must lie in 9..16");
      end
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("eep_2w_slave: PAGE_W must lie in 1..ADDR_W-1");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("eep_2w_slave: BUSY_CYCLES must be positive");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("eep_2w_slave: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic scl_s_w, sda_s_w, start_w, stop_w, rise_w, fall_w, busy_w;

   eep_2w_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl_i),
      .sda_i   (sda_i),
      .scl_o   (scl_s_w),
      .sda_o   (sda_s_w),
      .start_o (start_w),
      .stop_o  (stop_w),
      .rise_o  (rise_w),
      .fall_o  (fall_w)
   );

   eep_state_e        st_q;
   logic [3:0]        bit_q;
   logic              ack_ph_q, mack_q, rw_q, pull_q, pend_q, we_q;
   logic [7:0]        sh_q, tx_q, wdat_q;
   logic [AHI_W-1:0]  ahi_q;
   logic [ADDR_W-1:0] ctr_q, page_next, arr_next;
   logic              byte_ok;

   eep_2w_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
      .clk    (clk),
      .rst_n  (rst_n),
      .kick_i (we_q),
      .busy_o (busy_w)
   );

   assign page_next = {ctr_q[ADDR_W-1:PAGE_W], ctr_q[PAGE_W-1:0] + PAGE_W'(1)};
   assign arr_next  = ctr_q + ADDR_W'(1);

   always_comb begin
      case (st_q)
         ST_DEV:         byte_ok = (sh_q[7:4] == DEV_CODE) && !busy_w;
         ST_AHI, ST_ALO: byte_ok = 1'b1;
         ST_DATA:        byte_ok = !pend_q;
         default:        byte_ok = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         bit_q    <= '0;
         ack_ph_q <= 1'b0;
         mack_q   <= 1'b0;
         rw_q     <= 1'b0;
         pull_q   <= 1'b0;
         pend_q   <= 1'b0;
         we_q     <= 1'b0;
         sh_q     <= '0;
         tx_q     <= '0;
         wdat_q   <= '0;
         ahi_q    <= '0;
         ctr_q    <= '0;
      end else begin
         we_q <= 1'b0;
         if (start_w) begin
            st_q     <= ST_DEV;
            bit_q    <= '0;
            ack_ph_q <= 1'b0;
            pull_q   <= 1'b0;
            pend_q   <= 1'b0;
         end else if (stop_w) begin
            st_q     <= ST_IDLE;
            bit_q    <= '0;
            ack_ph_q <= 1'b0;
            pull_q   <= 1'b0;
            if (pend_q) begin
               we_q   <= 1'b1;
               pend_q <= 1'b0;
            end
         end else if (st_q == ST_RD) begin
            if (rise_w) begin
               if (ack_ph_q) mack_q <= ~sda_s_w;
               else          bit_q  <= bit_q + 4'd1;
            end
            if (fall_w) begin
               if (ack_ph_q) begin
                  ack_ph_q <= 1'b0;
                  bit_q    <= '0;
                  if (mack_q) begin
                     tx_q   <= {mem_rdata_i[6:0], 1'b0};
                     pull_q <= ~mem_rdata_i[7];
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end else if (bit_q == 4'd8) begin
                  pull_q   <= 1'b0;
                  ack_ph_q <= 1'b1;
                  ctr_q    <= arr_next;
               end else begin
                  pull_q <= ~tx_q[7];
                  tx_q   <= {tx_q[6:0], 1'b0};
               end
            end
         end else if (st_q != ST_IDLE) begin
            if (rise_w && !ack_ph_q) begin
               sh_q  <= {sh_q[6:0], sda_s_w};
               bit_q <= bit_q + 4'd1;
            end
            if (fall_w) begin
               if (ack_ph_q) begin
                  ack_ph_q <= 1'b0;
                  bit_q    <= '0;
                  pull_q   <= 1'b0;
                  case (st_q)
                     ST_DEV: begin
                        if (rw_q) begin
                           st_q   <= ST_RD;
                           tx_q   <= {mem_rdata_i[6:0], 1'b0};
                           pull_q <= ~mem_rdata_i[7];
                        end else begin
                           st_q <= ST_AHI;
                        end
                     end
                     ST_AHI:  st_q <= ST_ALO;
                     ST_ALO:  st_q <= ST_DATA;
                     default: ;
                  endcase
               end else if (bit_q == 4'd8) begin
                  if (byte_ok) begin
                     pull_q   <= 1'b1;
                     ack_ph_q <= 1'b1;
                     case (st_q)
                        ST_DEV:  rw_q  <= sh_q[0];
                        ST_AHI:  ahi_q <= sh_q[AHI_W-1:0];
                        ST_ALO:  ctr_q <= {ahi_q, sh_q};
                        ST_DATA: begin
                           pend_q <= 1'b1;
                           wdat_q <= sh_q;
                        end
                        default: ;
                     endcase
                  end else begin
                     st_q   <= ST_IDLE;
                     pull_q <= 1'b0;
                  end
               end
            end
         end
         if (we_q) ctr_q <= page_next;
      end
   end

   assign sda_pull_o  = pull_q;
   assign mem_we_o    = we_q;
   assign mem_addr_o  = ctr_q;
   assign mem_wdata_o = wdat_q;

endmodule

// File: rtl/eep_2w_checker.sv
module eep_2w_checker #(
   parameter int ADDR_W = 14,
   parameter int PAGE_W = 6
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    sda_pull_o,
   input logic                    mem_we_o,
   input logic [ADDR_W-1:0]       mem_addr_o,
   input logic                    busy_i,
   input logic                    stop_i,
   input logic                    scl_s_i,
   input eep_2w_pkg::eep_state_e  state_i
);
   import eep_2w_pkg::*;

   AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && state_i == ST_DEV) |-> !sda_pull_o); // R3

   AST_BUSY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> busy_i); // R3

   AST_WRITE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> $past(stop_i)); // R6

   AST_WRITE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> !mem_we_o); // R6

   AST_PAGE_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> mem_addr_o[ADDR_W-1:PAGE_W] == $past(mem_addr_o[ADDR_W-1:PAGE_W])); // R7

   AST_PAGE_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |=> mem_addr_o[PAGE_W-1:0] == PAGE_W'($past(mem_addr_o[PAGE_W-1:0]) + PAGE_W'(1))); // R7

   AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_o) |-> !scl_s_i); // R8

endmodule

bind eep_2w_slave eep_2w_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sda_pull_o (sda_pull_o),
   .mem_we_o   (mem_we_o),
   .mem_addr_o (mem_addr_o),
   .busy_i     (busy_w),
   .stop_i     (stop_w),
   .scl_s_i    (scl_s_w),
   .state_i    (st_q)
);

// File: tb/sim_eep_2w_slave.sv
module sim_eep_2w_slave;

   localparam int AW   = 14;
   localparam int PW   = 6;
   localparam int BUSY = 300;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          m_scl = 1'b1;
   logic          m_sda = 1'b1;
   logic          sda_pull;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic [7:0]    mem_rdata = 8'h00;
   wire           sda_line = m_sda & ~sda_pull;

   int tests = 0;
   int fails = 0;
   int we_cnt = 0;
   int last_wa = -1;
   int last_wd = -1;
   bit done = 1'b0;
   logic [7:0] wmem [int];

   always #10 clk = ~clk;

   eep_2w_slave #(.ADDR_W(AW), .PAGE_W(PW), .BUSY_CYCLES(BUSY)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (m_scl),
      .sda_i       (sda_line),
      .sda_pull_o  (sda_pull),
      .mem_we_o    (mem_we),
      .mem_addr_o  (mem_addr),
      .mem_wdata_o (mem_wdata),
      .mem_rdata_i (mem_rdata)
   );

   function automatic logic [7:0] pat(int a);
      return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
   endfunction

   function automatic logic [7:0] memval(int a);
      if (wmem.exists(a)) return wmem[a];
      return pat(a);
   endfunction

   always @(posedge clk) begin
      mem_rdata <= memval(int'(mem_addr));
      if (rst_n && mem_we) begin
         wmem[int'(mem_addr)] = mem_wdata;
         we_cnt++;
         last_wa = int'(mem_addr);
         last_wd = int'(mem_wdata);
      end
   end

   task automatic chk(string req, int act, int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic hclk(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic m_start();
      m_sda = 1'b1; hclk(4);
      m_scl = 1'b1; hclk(4);
      m_sda = 1'b0; hclk(4);
      m_scl = 1'b0; hclk(4);
   endtask

   task automatic m_stop();
      m_sda = 1'b0; hclk(4);
      m_scl = 1'b1; hclk(4);
      m_sda = 1'b1; hclk(8);
   endtask

   task automatic m_clk(input logic b, output logic s);
      m_sda = b; hclk(4);
      m_scl = 1'b1; hclk(4);
      @(negedge clk); s = sda_line;
      hclk(4);
      m_scl = 1'b0;
   endtask

   task automatic m_wbyte(input logic [7:0] d, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) m_clk(d[i], s);
      m_clk(1'b1, s);
      ack = ~s;
   endtask

   task automatic m_rbyte(input logic mack, output logic [7:0] d);
      logic s;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         m_clk(1'b1, s);
         d = {d[6:0], s};
      end
      m_clk(~mack, s);
   endtask

   task automatic t_reset();
      chk("R8 reset releases SDA", int'(sda_pull), 0);
      chk("R6 reset no write", int'(mem_we), 0);
      chk("R9 reset counter", int'(mem_addr), 0);
   endtask

   task automatic t_bad_code();
      logic a; logic [7:0] d;
      m_start();
      m_wbyte(8'hB1, a);
      chk("R2 wrong code refused", int'(a), 0);
      m_rbyte(1'b0, d);
      chk("R2 bus ignored after refusal", int'(d), 8'hFF);
      m_stop();
   endtask

   task automatic t_write_poll(int dev, int addr, int data);
      logic a, first; logic [7:0] d;
      int n0, polls, nxt;
      m_start();
      m_wbyte(8'(dev), a);   chk("R2 write device byte ack", int'(a), 1);
      m_wbyte(8'(addr >> 8), a); chk("R4 high address ack", int'(a), 1);
      m_wbyte(8'(addr), a);  chk("R4 low address ack", int'(a), 1);
      m_wbyte(8'(data), a);  chk("R5 data byte ack", int'(a), 1);
      n0 = we_cnt;
      m_stop();
      chk("R6 one write on stop", we_cnt - n0, 1);
      chk("R6 write address", last_wa, addr);
      chk("R6 write data", last_wd, data);
      polls = 0; first = 1'b1; a = 1'b0;
      while (!a && polls < 20) begin
         m_start();
         m_wbyte(8'hA1, a);
         if (polls == 0) first = a;
         polls++;
         if (!a) m_stop();
      end
      chk("R3 first poll refused", int'(first), 0);
      chk("R3 poll acknowledged after cycle", int'(a), 1);
      nxt = (addr & ~((1 << PW) - 1)) | ((addr + 1) & ((1 << PW) - 1));
      m_rbyte(1'b0, d);
      chk("R7 read after write uses page wrap", int'(d), int'(memval(nxt)));
      m_stop();
   endtask

   task automatic t_seq_read(int addr, int n);
      logic a; logic [7:0] d;
      int n0;
      n0 = we_cnt;
      m_start();
      m_wbyte(8'hA0, a);
      m_wbyte(8'(addr >> 8), a);
      m_wbyte(8'(addr), a);
      m_stop();
      chk("R11 address only makes no write", we_cnt - n0, 0);
      m_start();
      m_wbyte(8'hA1, a);
      chk("R11 no busy after address only", int'(a), 1);
      for (int i = 0; i < n; i++) begin
         m_rbyte(i != n - 1, d);
         chk("R8 R9 R10 sequential byte", int'(d),
             int'(memval((addr + i) & ((1 << AW) - 1))));
      end
      m_stop();
   endtask

   task automatic t_current(int exp_addr);
      logic a; logic [7:0] d;
      m_start();
      m_wbyte(8'hA1, a);
      chk("R8 current read ack", int'(a), 1);
      m_rbyte(1'b0, d);
      chk("R9 current address after wrap", int'(d), int'(memval(exp_addr)));
      m_rbyte(1'b0, d);
      chk("R10 released after master NACK", int'(d), 8'hFF);
      m_stop();
   endtask

   task automatic t_abort();
      logic a; logic [7:0] d;
      int n0;
      n0 = we_cnt;
      m_start();
      m_wbyte(8'hA0, a);
      m_wbyte(8'h03, a);
      m_wbyte(8'h00, a);
      m_wbyte(8'h77, a);
      m_start();
      m_wbyte(8'hA1, a);
      chk("R1 repeated start takes device byte", int'(a), 1);
      m_rbyte(1'b0, d);
      chk("R6 aborted data not stored", int'(d), int'(pat(16'h0300)));
      m_stop();
      chk("R6 no write after abort", we_cnt - n0, 0);
   endtask

   task automatic t_second_data();
      logic a;
      m_start();
      m_wbyte(8'hA0, a);
      m_wbyte(8'h02, a);
      m_wbyte(8'h00, a);
      m_wbyte(8'h11, a);
      m_wbyte(8'h22, a);
      chk("R5 second data byte refused", int'(a), 0);
      m_stop();
      chk("R5 first byte kept", last_wd, 8'h11);
      chk("R5 written at word address", last_wa, 16'h0200);
      hclk(BUSY + 100);
   endtask

   task automatic t_stop_mid();
      logic a, s; logic [7:0] d;
      m_start();
      m_clk(1'b1, s); m_clk(1'b0, s); m_clk(1'b1, s); m_clk(1'b0, s);
      m_stop();
      m_start();
      m_wbyte(8'hA1, a);
      chk("R1 fresh device byte after stop mid-byte", int'(a), 1);
      m_rbyte(1'b0, d);
      chk("R1 counter untouched by aborted byte", int'(d), int'(pat(16'h0201)));
      m_stop();
   endtask

   initial begin
      hclk(5);
      rst_n = 1'b1;
      hclk(5);
      t_reset();
      t_bad_code();
      t_write_poll(8'hA0, 16'h0123, 8'hA5);
      t_write_poll(8'hAE, 16'h007F, 8'h3C);
      t_seq_read(16'h007F, 2);
      t_seq_read(16'h3FFE, 3);
      t_current(16'h0001);
      t_abort();
      t_second_data();
      t_stop_mid();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule